// File: doc/BRIEF.md
# In-Place Bit-Reversed Pair Buffer

This block sits between a multi-lane FFT and the stage that splits one complex transform into the spectra of two real inputs. The FFT delivers each frame over a fixed number of cycles, one word per lane per cycle, in bit-reversed order. The split stage needs, for every bin k below N/2, the two words Z(k) and Z(N-k) together. These two words usually arrive in different cycles.

The block holds one whole frame in a single buffer. Each valid input cycle it reads the words for a group of bin pairs and writes that cycle's new input words into the same locations. The old contents come out while the new word goes in. The lower half of the lanes is addressed with a mirrored column order on alternate frames and with a straight order in between. After two frames the storage layout is back where it started. Output is valid one cycle after each valid input beat, and only once a complete frame has been stored.

Top module: `pairbuf_top`

## Requirements
- R1: After reset `outValid` stays low for the whole first frame. No pair is emitted until one complete frame (N/8 valid beats with the default eight lanes) has been stored.
- R2: Input lane p on the q-th valid beat of a frame carries bin p*C + rev(q). Here C = N/LANES, and rev reverses the log2(C) bits of q.
- R3: Each emission carries LANES/2 pairs. Pair p has index k = p*C + rev(s), where s is the beat number within the frame. The k values rise strictly from pair 0 upward and all stay below N/2.
- R4: The upper word of pair p equals Z(k) of the previously completed frame.
- R5: The lower word of pair p equals Z(N-k) of the same frame. For k = 0 it is Z(N/2).
- R6: Each emission appears one clock after the valid input beat that causes it. There is exactly one emission per valid beat once the buffer holds a frame.
- R7: Pairing stays correct across any number of back-to-back frames. This holds while the lower-lane column order alternates between the mirrored mode and the straight mode at every frame boundary.
- R8: A cycle with `inValid` low emits nothing, leaves all outputs unchanged and does not advance the beat position. The lane data is ignored in that cycle. This is true between frames and in the middle of a frame.
- R9: A stored frame is kept across any idle time. Its pairs are emitted when the next frame's beats arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Lane data valid this cycle |
| inLanes | input | LANES*DW | Lane words, lane p at bits [p*DW +: DW] |
| outValid | output | 1 | Pair group valid |
| outUpper | output | LANES/2*DW | Z(k) for pair p at [p*DW +: DW] |
| outLower | output | LANES/2*DW | Z(N-k) for pair p at [p*DW +: DW] |
| outK | output | LANES/2*log2(N) | Bin index k for pair p |

## Verification
The hardest case to reach is the mirrored mode. In that mode the lower lanes read a column that is not the current beat's column, and a word written on one beat must survive until the column is read on a later beat of the next frame. The stimulus reaches this case in two ways. It streams many consecutive frames with bin values tagged by frame number, so both modes are exercised repeatedly and a word from the wrong frame or the wrong column is visible. It also inserts idle cycles inside a frame, between frames and around a reset in mid-run, so the beat position and the mode parity must both be kept across stalls.

// File: rtl/pairbuf_pkg.sv
package pairbuf_pkg;

  typedef enum logic {
    MODE_SEQ = 1'b0,
    MODE_FB  = 1'b1
  } addrMode_e;

  // reverse the low `bits` bits of v
  function automatic logic [15:0] bitRev(input logic [15:0] v, input int bits);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < bits; i++) r[i] = v[bits-1-i];
    return r;
  endfunction

endpackage

// File: rtl/pairbuf_ctrl.sv
module pairbuf_ctrl
  import pairbuf_pkg::*;
#(
  parameter int COLS = 4,
  parameter int CW   = 2,
  parameter type strobe_t = logic
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strb
);

  logic [CW-1:0] stepQ;
  addrMode_e     modeQ;
  logic          filledQ;
  logic          lastBeat;
  logic [CW-1:0] revStep;
  logic [CW-1:0] negRev;
  logic [CW-1:0] mirrorCol;

  assign lastBeat = inValid && (stepQ == CW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ   <= '0;
      modeQ   <= MODE_SEQ;
      filledQ <= 1'b0;
    end else if (inValid) begin
      stepQ <= lastBeat ? '0 : stepQ + 1'b1;
      if (lastBeat) begin
        modeQ   <= (modeQ == MODE_SEQ) ? MODE_FB : MODE_SEQ;
        filledQ <= 1'b1;
      end
    end
  end

  // lower column holding the partner of the upper column: rev(C - rev(step))
  always_comb begin
    revStep   = CW'(bitRev(16'(stepQ), CW));
    negRev    = '0 - revStep;
    mirrorCol = CW'(bitRev(16'(negRev), CW));
  end

  always_comb begin
    strb.wr    = inValid;
    strb.emit  = inValid && filledQ;
    strb.upCol = stepQ;
    strb.loCol = (modeQ == MODE_FB) ? mirrorCol : stepQ;
    strb.rev   = revStep;
  end

endmodule

// File: rtl/pairbuf_dp.sv
module pairbuf_dp #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int COLS  = 4,
  parameter int CW    = 2,
  parameter int KW    = 5,
  parameter type strobe_t = logic
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strb,
  input  logic [LANES*DW-1:0]      inLanes,
  output logic                     outValid,
  output logic [LANES/2*DW-1:0]    outUpper,
  output logic [LANES/2*DW-1:0]    outLower,
  output logic [LANES/2*KW-1:0]    outK
);

  localparam int G = LANES / 2;

  logic [LANES-1:0][DW-1:0] rdAll;
  logic                     validQ;
  logic [CW-1:0]            revQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] mem [COLS];
    logic [DW-1:0] rdQ;
    logic [CW-1:0] addr;

    if (l < G) begin : g_up
      assign addr = strb.upCol;
    end else begin : g_lo
      assign addr = strb.loCol;
    end

    // read-first: old word leaves while the new word lands
    always_ff @(posedge clk) begin
      if (strb.wr) mem[addr] <= inLanes[l*DW +: DW];
    end

    always_ff @(posedge clk) begin
      if (rst)          rdQ <= '0;
      else if (strb.wr) rdQ <= mem[addr];
    end

    assign rdAll[l] = rdQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      revQ   <= '0;
    end else begin
      validQ <= strb.emit;
      if (strb.wr) revQ <= strb.rev;
    end
  end

  assign outValid = validQ;

  for (genvar p = 0; p < G; p++) begin : g_pair
    localparam int JZERO = (p == 0) ? 0 : G - p;
    localparam int JMIR  = G - 1 - p;
    localparam logic [KW-1:0] BASE = KW'(p * COLS);

    assign outUpper[p*DW +: DW] = rdAll[p];
    assign outLower[p*DW +: DW] = (revQ == '0) ? rdAll[G + JZERO] : rdAll[G + JMIR];
    assign outK[p*KW +: KW]     = BASE | {{(KW-CW){1'b0}}, revQ};
  end

endmodule

// File: rtl/pairbuf_top.sv
module pairbuf_top #(
  parameter int N     = 32,
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic [LANES*DW-1:0]          inLanes,
  output logic                         outValid,
  output logic [LANES/2*DW-1:0]        outUpper,
  output logic [LANES/2*DW-1:0]        outLower,
  output logic [LANES/2*$clog2(N)-1:0] outK
);

  localparam int COLS = N / LANES;
  localparam int CW   = $clog2(COLS);
  localparam int KW   = $clog2(N);

  typedef struct packed {
    logic          wr;
    logic          emit;
    logic [CW-1:0] upCol;
    logic [CW-1:0] loCol;
    logic [CW-1:0] rev;
  } strobe_t;

  strobe_t strb;

  pairbuf_ctrl #(.COLS(COLS), .CW(CW), .strobe_t(strobe_t)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strb    (strb)
  );

  pairbuf_dp #(
    .LANES(LANES), .DW(DW), .COLS(COLS), .CW(CW), .KW(KW), .strobe_t(strobe_t)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inLanes  (inLanes),
    .outValid (outValid),
    .outUpper (outUpper),
    .outLower (outLower),
    .outK     (outK)
  );

endmodule

// File: rtl/pairbuf_checker.sv
module pairbuf_checker #(
  parameter int N     = 32,
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         inValid,
  input logic                         outValid,
  input logic [LANES/2*DW-1:0]        outUpper,
  input logic [LANES/2*DW-1:0]        outLower,
  input logic [LANES/2*$clog2(N)-1:0] outK
);

  localparam int G    = LANES / 2;
  localparam int COLS = N / LANES;
  localparam int CW   = $clog2(COLS);
  localparam int KW   = $clog2(N);

  logic [CW:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst)                                  fillCnt <= '0;
    else if (inValid && fillCnt < (CW+1)'(COLS)) fillCnt <= fillCnt + 1'b1;
  end

  assert_no_early_output_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (fillCnt == (CW+1)'(COLS)))
    else $error("R1 emission before a full frame stored");

  assert_emit_after_beat_R6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid))
    else $error("R6 emission without a preceding beat");

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outUpper) && $stable(outLower) && $stable(outK)))
    else $error("R8 outputs moved on an idle cycle");

  assert_k_below_half_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outK[(G-1)*KW +: KW] < KW'(N/2)))
    else $error("R3 bin index not below N/2");

  for (genvar p = 1; p < G; p++) begin : g_ord
    assert_k_rising_R3: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (outK[p*KW +: KW] > outK[(p-1)*KW +: KW]))
      else $error("R3 bin indices not rising");
  end

endmodule

bind pairbuf_top pairbuf_checker #(.N(N), .LANES(LANES), .DW(DW)) chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outUpper (outUpper),
  .outLower (outLower),
  .outK     (outK)
);

// File: tb/tb_pairbuf_top.sv
module tb_pairbuf_top;

  localparam int N     = 32;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int G     = LANES / 2;
  localparam int COLS  = N / LANES;
  localparam int CW    = $clog2(COLS);
  localparam int KW    = $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic [LANES*DW-1:0]  inLanes = '0;
  logic                 outValid;
  logic [G*DW-1:0]      outUpper;
  logic [G*DW-1:0]      outLower;
  logic [G*KW-1:0]      outK;

  pairbuf_top #(.N(N), .LANES(LANES), .DW(DW)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inLanes(inLanes),
    .outValid(outValid), .outUpper(outUpper), .outLower(outLower), .outK(outK)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [G-1:0][KW-1:0] k;
    logic [G-1:0][DW-1:0] up;
    logic [G-1:0][DW-1:0] lo;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  int    emitCount = 0;
  int    prevFrame = 0;
  bit    havePrev = 0;
  bit    done = 0;

  function automatic int revBits(int v, int bits);
    int r = 0;
    for (int i = 0; i < bits; i++) if (v[i]) r |= 1 << (bits - 1 - i);
    return r;
  endfunction

  function automatic logic [DW-1:0] binVal(int f, int b);
    return DW'(((f % 256) * 256) + b);
  endfunction

  function automatic int partnerOf(int k);
    return (k == 0) ? N / 2 : N - k;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected group per emission
  always @(negedge clk) begin
    if (!rst && outValid) begin
      emitCount++;
      if (expQ.size() == 0) begin
        check(0, "R1 R6 unexpected emission", 1, 0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        for (int p = 0; p < G; p++) begin
          check(outK[p*KW +: KW] == e.k[p], "R3 bin index", outK[p*KW +: KW], e.k[p]);
          check(outUpper[p*DW +: DW] == e.up[p], "R2 R4 R7 upper word",
                outUpper[p*DW +: DW], e.up[p]);
          check(outLower[p*DW +: DW] == e.lo[p], "R2 R5 R7 lower word",
                outLower[p*DW +: DW], e.lo[p]);
        end
      end
    end
  end

  // idle cycles with junk lane data; outputs must hold (R8)
  task automatic idle(int n);
    logic [G*DW-1:0] snapU, snapL;
    logic [G*KW-1:0] snapK;
    snapU = '0; snapL = '0; snapK = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(!outValid, "R8 no emission when idle", outValid, 0);
        check(outUpper == snapU && outLower == snapL && outK == snapK,
              "R8 outputs hold", outUpper, snapU);
      end
      snapU = outUpper; snapL = outLower; snapK = outK;
      inValid = 1'b0;
      for (int l = 0; l < LANES; l++) inLanes[l*DW +: DW] = DW'($urandom);
    end
    @(negedge clk);
    check(!outValid, "R8 no emission when idle", outValid, 0);
    check(outUpper == snapU && outLower == snapL, "R8 outputs hold", outUpper, snapU);
  endtask

  // driver: one frame in bit-reversed lane order; queues expected pairs of the previous frame
  task automatic driveFrame(int f, int gapAt, int gapLen);
    for (int q = 0; q < COLS; q++) begin
      if (q == gapAt) idle(gapLen);
      @(negedge clk);
      inValid = 1'b1;
      for (int p = 0; p < LANES; p++)
        inLanes[p*DW +: DW] = binVal(f, p * COLS + revBits(q, CW));
      if (havePrev) begin
        item_t e;
        for (int p = 0; p < G; p++) begin
          int k;
          k = p * COLS + revBits(q, CW);
          e.k[p]  = KW'(k);
          e.up[p] = binVal(prevFrame, k);
          e.lo[p] = binVal(prevFrame, partnerOf(k));
        end
        expQ.push_back(e);
      end
    end
    prevFrame = f;
    havePrev  = 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    havePrev = 0;
    repeat (2) @(negedge clk);
    check(!outValid, "R1 reset state", outValid, 0);
    rst = 1'b0;
  endtask

  initial begin
    int cnt0;
    doReset();
    // fill frame: nothing may come out
    driveFrame(0, -1, 0);
    idle(2);
    check(emitCount == 0, "R1 first frame silent", emitCount, 0);
    // back-to-back frames, both addressing modes many times
    for (int f = 1; f <= 5; f++) driveFrame(f, -1, 0);
    // stall in the middle of a frame
    driveFrame(6, 2, 3);
    driveFrame(7, 1, 1);
    // long idle, then the held frame must still be emitted
    idle(6);
    cnt0 = emitCount;
    driveFrame(8, -1, 0);
    idle(1);
    check(emitCount - cnt0 == COLS, "R9 held frame emitted", emitCount - cnt0, COLS);
    driveFrame(9, -1, 0);
    driveFrame(10, 3, 2);
    idle(2);
    // reset in mid-run, then refill
    doReset();
    cnt0 = emitCount;
    driveFrame(20, -1, 0);
    idle(2);
    check(emitCount == cnt0, "R1 silent after second reset", emitCount - cnt0, 0);
    for (int f = 21; f <= 25; f++) driveFrame(f, -1, 0);
    idle(3);
    check(expQ.size() == 0, "R6 every queued group emitted", expQ.size(), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule